// File: doc/BRIEF.md
# Receive Ring Page Manager

This block keeps the pointers of a circular receive buffer made of 256-byte pages. The ring lies between a first page (`ring_lo_i`) and a limit page (`ring_hi_i`, not part of the ring). The receive path signals frame start, one pulse per stored byte (data and the trailing CRC bytes alike) and frame end with a good/bad verdict. The block returns the byte address to write, as page and in-page offset.

A write pointer (`curr_o`) marks where the next frame starts. A host-owned read boundary (`bnry_o`) marks the oldest page not yet consumed. Before the fill moves into a new page, it checks that page against the boundary. If the two match, the frame is dropped and a sticky overwrite warning is raised.

An accepted frame moves the write pointer past its last used page. A dropped or rejected frame leaves the pointer unchanged and returns the fill address to it. The block also flags full and empty rings by comparing the two pointers, with wrap-around taken into account.

Top module: `rx_ring_mgr`

## Requirements
- R1: Page advance wraps: when the page after the current fill page would equal `ring_hi_i`, the fill continues at `ring_lo_i`.
- R2: `full_o` is 1 exactly when `bnry_o` equals `curr_o`.
- R3: `empty_o` is 1 exactly when `bnry_o` equals the page before `curr_o`, where the page before `ring_lo_i` is `ring_hi_i - 1`.
- R4: A frame is dropped (`abort_o` = 1) when it starts while `curr_o` equals `bnry_o`, or when the fill would advance into the page equal to `bnry_o`. While it is dropped, further byte pulses leave `wr_addr_o` unchanged.
- R5: A drop sets `ovw_o`, which stays 1 until a cycle with `ovw_clr_i` = 1 and no new drop. A new drop wins over a clear.
- R6: On frame end with `frm_ok_i` = 0, or for a dropped frame, `curr_o` is unchanged and the next cycle shows `wr_addr_o` = {`curr_o`, 8'h00}.
- R7: On frame end of a frame that is not dropped, with `frm_ok_i` = 1, `curr_o` becomes the page after the last page holding a byte of the frame. A page entered with offset 0 and no byte written in it does not count. After the update, `wr_addr_o` = {new `curr_o`, 8'h00}.
- R8: `wr_addr_o` is {page[7:0], offset[7:0]}. Each accepted byte pulse, CRC bytes included, moves it to the next byte, and offset 8'hFF rolls to offset 0 of the next ring page. A frame starts at {`curr_o`, 8'h00}.
- R9: After reset `curr_o`, `bnry_o` and `wr_addr_o` are 0, and `ovw_o` and `abort_o` are 0. `init_i` loads `curr_o` with `ring_lo_i` and sets `wr_addr_o` to {`ring_lo_i`, 8'h00}.
- R10: `bnry_wr_i` loads `bnry_o` from `bnry_i` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_lo_i | input | 8 | First page of the ring |
| ring_hi_i | input | 8 | Limit page (one past the last ring page) |
| init_i | input | 1 | Load the write pointer with the first page |
| bnry_wr_i | input | 1 | Host write strobe for the boundary |
| bnry_i | input | 8 | Boundary value to load |
| ovw_clr_i | input | 1 | Clear the overwrite warning |
| frm_start_i | input | 1 | Frame begins |
| byte_wr_i | input | 1 | One byte stored at `wr_addr_o` |
| frm_end_i | input | 1 | Frame ends |
| frm_ok_i | input | 1 | Frame verdict at end: 1 good, 0 reject |
| wr_addr_o | output | 16 | Byte address {page, offset} |
| curr_o | output | 8 | Write pointer page |
| bnry_o | output | 8 | Read boundary page |
| abort_o | output | 1 | Current frame is being dropped |
| ovw_o | output | 1 | Sticky overwrite warning |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | Ring empty |

## Verification
The bench runs a frame that crosses the limit page. A design with a wrong wrap would send the fill to the limit page instead of the first page. It also checks a frame whose last byte lands exactly at offset FF, where counting the empty next page would skip a page in `curr_o`.

Overruns are tested both at frame start and in the middle of a frame. A defect here would overwrite unread pages, keep moving the address after the drop, or lose the warning before the host clears it. Rejected frames must bring the address back to the saved pointer. The empty test with the pointer at the first page catches a "minus one" that does not wrap.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DROP = 2'd2
  } fill_state_e;
endpackage

// File: rtl/ring_step.sv
module ring_step #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] lo_i,
  input  logic [PW-1:0] hi_i,
  output logic [PW-1:0] nxt_o,
  output logic [PW-1:0] prv_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  always_comb begin
    nxt_o = (page_i + ONE == hi_i) ? lo_i : page_i + ONE;
    prv_o = (page_i == lo_i) ? hi_i - ONE : page_i - ONE;
  end
endmodule

// File: rtl/ring_fill_ctrl.sv
module ring_fill_ctrl
  import ring_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [PW-1:0] lo_i,
  input  logic [PW-1:0] curr_i,
  input  logic [PW-1:0] bnry_i,
  input  logic          frm_start_i,
  input  logic          byte_wr_i,
  input  logic          frm_end_i,
  input  logic          frm_ok_i,
  input  logic [PW-1:0] wnext_i,
  output logic [PW-1:0] wpage_o,
  output logic [OW-1:0] wofs_o,
  output fill_state_e   state_o,
  output logic          ovf_o,
  output logic          commit_o,
  output logic [PW-1:0] commit_page_o
);
  localparam logic [OW-1:0] OFS_LAST = '1;

  logic start_go, end_go, byte_go, roll, hit;

  always_comb begin
    start_go      = frm_start_i & ~init_i;
    end_go        = frm_end_i & ~init_i & ~frm_start_i;
    byte_go       = byte_wr_i & ~init_i & ~frm_start_i & ~frm_end_i & (state_o == FILL_RUN);
    roll          = byte_go & (wofs_o == OFS_LAST);
    hit           = wnext_i == bnry_i;
    commit_o      = end_go & frm_ok_i & (state_o == FILL_RUN);
    // a page entered at offset 0 holds nothing yet
    commit_page_o = (wofs_o == '0) ? wpage_o : wnext_i;
    ovf_o         = (start_go & (curr_i == bnry_i)) | (roll & hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= FILL_IDLE;
      wpage_o <= '0;
      wofs_o  <= '0;
    end else if (init_i) begin
      state_o <= FILL_IDLE;
      wpage_o <= lo_i;
      wofs_o  <= '0;
    end else if (start_go) begin
      state_o <= (curr_i == bnry_i) ? FILL_DROP : FILL_RUN;
      wpage_o <= curr_i;
      wofs_o  <= '0;
    end else if (end_go) begin
      state_o <= FILL_IDLE;
      wpage_o <= commit_o ? commit_page_o : curr_i;
      wofs_o  <= '0;
    end else if (roll) begin
      if (hit) begin
        state_o <= FILL_DROP;
      end else begin
        wpage_o <= wnext_i;
        wofs_o  <= '0;
      end
    end else if (byte_go) begin
      wofs_o <= wofs_o + OW'(1);
    end
  end
endmodule

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [PW-1:0] lo_i,
  input  logic          commit_i,
  input  logic [PW-1:0] commit_page_i,
  input  logic          bnry_wr_i,
  input  logic [PW-1:0] bnry_i,
  input  logic          ovf_i,
  input  logic          ovw_clr_i,
  output logic [PW-1:0] curr_o,
  output logic [PW-1:0] bnry_o,
  output logic          ovw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      curr_o <= '0;
      bnry_o <= '0;
      ovw_o  <= 1'b0;
    end else begin
      if (init_i)        curr_o <= lo_i;
      else if (commit_i) curr_o <= commit_page_i;
      if (bnry_wr_i)     bnry_o <= bnry_i;
      if (ovf_i)         ovw_o  <= 1'b1;
      else if (ovw_clr_i) ovw_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import ring_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 8,
  localparam int AW = PW + OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ring_lo_i,
  input  logic [PW-1:0] ring_hi_i,
  input  logic          init_i,
  input  logic          bnry_wr_i,
  input  logic [PW-1:0] bnry_i,
  input  logic          ovw_clr_i,
  input  logic          frm_start_i,
  input  logic          byte_wr_i,
  input  logic          frm_end_i,
  input  logic          frm_ok_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [PW-1:0] curr_o,
  output logic [PW-1:0] bnry_o,
  output logic          abort_o,
  output logic          ovw_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wpage, wofs_unused_nxt, wnext, curr_prv, commit_page;
  logic [OW-1:0] wofs;
  logic          ovf, commit, filling;
  fill_state_e   state;
  logic [PW-1:0] curr_nxt_unused;

  ring_step #(.PW(PW)) u_step_w (
    .page_i(wpage), .lo_i(ring_lo_i), .hi_i(ring_hi_i),
    .nxt_o(wnext), .prv_o(wofs_unused_nxt)
  );

  ring_step #(.PW(PW)) u_step_c (
    .page_i(curr_o), .lo_i(ring_lo_i), .hi_i(ring_hi_i),
    .nxt_o(curr_nxt_unused), .prv_o(curr_prv)
  );

  ring_fill_ctrl #(.PW(PW), .OW(OW)) u_fill (
    .clk_i, .rst_ni, .init_i,
    .lo_i(ring_lo_i), .curr_i(curr_o), .bnry_i(bnry_o),
    .frm_start_i, .byte_wr_i, .frm_end_i, .frm_ok_i,
    .wnext_i(wnext), .wpage_o(wpage), .wofs_o(wofs), .state_o(state),
    .ovf_o(ovf), .commit_o(commit), .commit_page_o(commit_page)
  );

  ring_ptr_regs #(.PW(PW)) u_ptr (
    .clk_i, .rst_ni, .init_i, .lo_i(ring_lo_i),
    .commit_i(commit), .commit_page_i(commit_page),
    .bnry_wr_i, .bnry_i, .ovf_i(ovf), .ovw_clr_i,
    .curr_o, .bnry_o, .ovw_o
  );

  assign filling   = state == FILL_RUN;
  assign abort_o   = state == FILL_DROP;
  assign wr_addr_o = {wpage, wofs};
  assign full_o    = bnry_o == curr_o;
  assign empty_o   = bnry_o == curr_prv;
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int PW = 8,
  parameter int OW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_i,
  input logic          frm_start_i,
  input logic          frm_end_i,
  input logic          frm_ok_i,
  input logic          byte_wr_i,
  input logic          ovw_clr_i,
  input logic [PW-1:0] ring_lo_i,
  input logic [PW-1:0] ring_hi_i,
  input logic [PW+OW-1:0] wr_addr_o,
  input logic [PW-1:0] curr_o,
  input logic [PW-1:0] bnry_o,
  input logic          abort_o,
  input logic          ovw_o,
  input logic          filling
);
  logic cfg_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_ok <= 1'b0;
    else if (init_i) cfg_ok <= ring_lo_i < ring_hi_i;
  end

  // R6
  a_r6_rollback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_end_i && !frm_start_i && !init_i && !(frm_ok_i && filling))
      |=> (wr_addr_o == {curr_o, {OW{1'b0}}}) && $stable(curr_o));

  // R5
  a_r5_ovw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovw_o && !ovw_clr_i) |=> ovw_o);

  // R4 / R5
  a_r4_drop_warns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> ovw_o);

  // R4
  a_r4_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !frm_end_i && !frm_start_i && !init_i) |=> $stable(wr_addr_o));

  // R1
  a_r1_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ok && filling) |-> (wr_addr_o[PW+OW-1:OW] >= ring_lo_i) &&
                            (wr_addr_o[PW+OW-1:OW] < ring_hi_i));

  // R4: accepted bytes never land in the boundary page
  a_r4_no_clobber: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filling && byte_wr_i) |-> (wr_addr_o[PW+OW-1:OW] != bnry_o));
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PW(PW), .OW(OW)) u_chk (
  .clk_i, .rst_ni, .init_i, .frm_start_i, .frm_end_i, .frm_ok_i,
  .byte_wr_i, .ovw_clr_i, .ring_lo_i, .ring_hi_i, .wr_addr_o,
  .curr_o, .bnry_o, .abort_o, .ovw_o, .filling(filling)
);

// File: tb/sim_rx_ring_mgr.sv
`timescale 1ns/1ps
module sim_rx_ring_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  lo, hi, bnry_in;
  logic        init, bnry_wr, ovw_clr, fstart, bwr, fend, fok;
  logic [15:0] wr_addr;
  logic [7:0]  curr, bnry;
  logic        abort, ovw, full, empty;

  rx_ring_mgr u0 (
    .clk_i(clk), .rst_ni(rst_n), .ring_lo_i(lo), .ring_hi_i(hi),
    .init_i(init), .bnry_wr_i(bnry_wr), .bnry_i(bnry_in), .ovw_clr_i(ovw_clr),
    .frm_start_i(fstart), .byte_wr_i(bwr), .frm_end_i(fend), .frm_ok_i(fok),
    .wr_addr_o(wr_addr), .curr_o(curr), .bnry_o(bnry), .abort_o(abort),
    .ovw_o(ovw), .full_o(full), .empty_o(empty)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) fstart = 1'b1;
    @(negedge clk) fstart = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    if (n > 0) begin
      @(negedge clk) bwr = 1'b1;
      repeat (n) @(negedge clk);
      bwr = 1'b0;
    end
  endtask

  task automatic pulse_end(input logic ok);
    @(negedge clk) begin fend = 1'b1; fok = ok; end
    @(negedge clk) begin fend = 1'b0; fok = 1'b0; end
  endtask

  task automatic set_bnry(input logic [7:0] v);
    @(negedge clk) begin bnry_wr = 1'b1; bnry_in = v; end
    @(negedge clk) bnry_wr = 1'b0;
  endtask

  task automatic clear_ovw();
    @(negedge clk) ovw_clr = 1'b1;
    @(negedge clk) ovw_clr = 1'b0;
  endtask

  typedef struct packed {
    logic        set_b;
    logic [7:0]  bval;
    logic        clr;
    logic [15:0] nbytes;
    logic        ok;
    logic [7:0]  e_curr;
    logic        e_abort;
    logic        e_full;
    logic        e_empty;
    logic        e_ovw;
  } row_t;

  // ring 0x40..0x45, boundary 0x45 after init
  localparam row_t ROWS [7] = '{
    '{1'b0, 8'h00, 1'b0, 16'd100, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 16'd256, 1'b1, 8'h42, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 16'd300, 1'b0, 8'h42, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 16'd600, 1'b1, 8'h45, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 16'd10,  1'b1, 8'h45, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b1, 8'h43, 1'b1, 16'd300, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 16'd600, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    lo = 8'h40; hi = 8'h46; bnry_in = '0;
    init = 0; bnry_wr = 0; ovw_clr = 0; fstart = 0; bwr = 0; fend = 0; fok = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset curr", curr, 0);
    chk("R9 reset bnry", bnry, 0);
    chk("R9 reset addr", wr_addr, 0);
    chk("R9 reset ovw/abort", {ovw, abort}, 0);
    rst_n = 1'b1;
    @(negedge clk) init = 1'b1;
    @(negedge clk) init = 1'b0;
    chk("R9 init curr", curr, 8'h40);
    chk("R9 init addr", wr_addr, 16'h4000);
    set_bnry(8'h45);
    chk("R10 bnry load", bnry, 8'h45);
    chk("R3 empty wrap at first page", empty, 1);
    chk("R2 not full", full, 0);

    for (int i = 0; i < 7; i++) begin
      if (ROWS[i].set_b) set_bnry(ROWS[i].bval);
      if (ROWS[i].clr) clear_ovw();
      pulse_start();
      send_bytes(int'(ROWS[i].nbytes));
      chk($sformatf("R4 row%0d abort", i), abort, ROWS[i].e_abort);
      pulse_end(ROWS[i].ok);
      chk($sformatf("R7 R6 R1 row%0d curr", i), curr, ROWS[i].e_curr);
      chk($sformatf("R6 R7 row%0d addr", i), wr_addr, {ROWS[i].e_curr, 8'h00});
      chk($sformatf("R2 row%0d full", i), full, ROWS[i].e_full);
      chk($sformatf("R3 row%0d empty", i), empty, ROWS[i].e_empty);
      chk($sformatf("R5 row%0d ovw", i), ovw, ROWS[i].e_ovw);
    end

    // R8 consecutive addresses across a page edge (curr 0x41)
    set_bnry(8'h40);
    clear_ovw();
    pulse_start();
    chk("R8 frame start addr", wr_addr, 16'h4100);
    send_bytes(260);
    chk("R8 addr after 260 bytes", wr_addr, 16'h4204);
    pulse_end(1'b1);
    chk("R7 curr after 260", curr, 8'h43);

    set_bnry(8'h42);
    chk("R3 empty no wrap", empty, 1);
    set_bnry(8'h43);
    chk("R2 full", full, 1);

    // R4 drop at start; bytes ignored
    pulse_start();
    chk("R4 drop at start", abort, 1);
    send_bytes(5);
    chk("R4 addr frozen", wr_addr, 16'h4300);
    repeat (5) @(negedge clk);
    chk("R5 ovw held", ovw, 1);
    clear_ovw();
    chk("R5 ovw cleared", ovw, 0);
    pulse_end(1'b1);
    chk("R6 dropped keeps curr", curr, 8'h43);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule